// File: doc/BRIEF.md
# Byte Alignment Data Unit

This unit builds a misaligned 64-bit doubleword out of two aligned ones. It runs in two steps. First, an address-alignment operation adds two integer operands. It returns the sum rounded down to an 8-byte boundary and records the discarded low bits, the byte offset, in a 64-bit status register. Second, a data-alignment operation treats two floating-point doublewords as one 16-byte stream and extracts the 8 bytes that start at the recorded offset. Software therefore computes an address once and can then extract any number of doublewords at that alignment without recomputing the offset.

A 9-bit opcode selects one of three operations: address alignment, a little-endian variant of it, and data alignment. A separate register port reads and writes the status register as ancillary register 0x13. When the floating-point unit is disabled, every operation and every status access raises a trap flag instead of executing. Opcodes outside the three known values raise an illegal-operation flag. Results and flags are registered, and the unit uses a synchronous active-high reset.

Top module: `byte_align_unit`

## Requirements
- R1: After reset `int_result` and `fp_result` are zero, both flags are low, and the status register reads as zero.
- R2: Opcode 0x018 with `op_valid` and `fpu_en` high sets `int_result` to `int_a + int_b` with bits 2:0 cleared. It also loads bits 2:0 of the sum into status bits 2:0 and leaves status bits 63:3 unchanged.
- R3: Opcode 0x01A gives the same `int_result` as R2. It loads status bits 2:0 with (8 − sum[2:0]) mod 8 and leaves the other status bits unchanged.
- R4: Opcode 0x048 sets `fp_result` to (`fp_a` << 8k) | (`fp_b` >> (64 − 8k)), where k is status bits 2:0. When k = 0 the result is exactly `fp_a`.
- R5: With `op_valid` high, any other opcode pulses `illegal_op` for one cycle whatever `fpu_en` is. It leaves both results and the status register unchanged and does not raise `fpu_trap`.
- R6: A known opcode, or an access to register 0x13, made while `fpu_en` is low pulses `fpu_trap` for one cycle. It changes neither the results nor the status register.
- R7: With `fpu_en` high and `aux_sel` = 0x13, `aux_wr` loads all 64 bits of `aux_wdata` into the status register, and `aux_rd` places the status register on `int_result`.
- R8: Results and flags appear on the first rising edge after the stimulus. Both flags are low on any cycle without a new trapping or illegal request, and the results hold their values until another operation or read updates them.
- R9: A register access is ignored when `aux_sel` is not 0x13 or when `op_valid` is high in the same cycle. In that case the operation is carried out alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 9 | Operation select |
| int_a | input | 64 | First integer operand |
| int_b | input | 64 | Second integer operand |
| fp_a | input | 64 | First floating-point operand (upper part of the stream) |
| fp_b | input | 64 | Second floating-point operand (lower part of the stream) |
| fpu_en | input | 1 | Floating-point unit enabled |
| aux_rd | input | 1 | Ancillary register read |
| aux_wr | input | 1 | Ancillary register write |
| aux_sel | input | 5 | Ancillary register number |
| aux_wdata | input | 64 | Ancillary register write data |
| int_result | output | 64 | Aligned address or status read data |
| fp_result | output | 64 | Aligned data |
| fpu_trap | output | 1 | Disabled floating-point unit trap |
| illegal_op | output | 1 | Illegal operation flag |

## Verification
Every result, flag and status update appears one rising edge after the cycle that carries the request. The bench drives each request on a falling edge, returns the controls to idle on the next falling edge, and samples the outputs at that same point, half a period after the edge that registered them. The status register has no output of its own, so its value is always observed through a following register read or data alignment. Each ignored or trapped request is followed by such a read before anything else can change the register.

// File: rtl/bau_pkg.sv
package bau_pkg;
  localparam int OPC_W = 9;
  localparam int AUX_W = 5;

  localparam logic [OPC_W-1:0] OPC_ALIGN_ADDR    = 9'h018;
  localparam logic [OPC_W-1:0] OPC_ALIGN_ADDR_LE = 9'h01A;
  localparam logic [OPC_W-1:0] OPC_ALIGN_DATA    = 9'h048;
  localparam logic [AUX_W-1:0] AUX_STATUS_ID     = 5'h13;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_ADDR,
    ACT_ADDR_LE,
    ACT_DATA,
    ACT_SR_WR,
    ACT_SR_RD,
    ACT_TRAP,
    ACT_ILLEGAL
  } act_e;
endpackage

// File: rtl/bau_decode.sv
module bau_decode
  import bau_pkg::*;
(
  input  logic             op_valid,
  input  logic [OPC_W-1:0] op_code,
  input  logic             fpu_en,
  input  logic             aux_rd,
  input  logic             aux_wr,
  input  logic [AUX_W-1:0] aux_sel,
  output act_e             act
);
  always_comb begin
    act = ACT_NONE;
    if (op_valid) begin
      case (op_code)
        OPC_ALIGN_ADDR:    act = fpu_en ? ACT_ADDR    : ACT_TRAP;
        OPC_ALIGN_ADDR_LE: act = fpu_en ? ACT_ADDR_LE : ACT_TRAP;
        OPC_ALIGN_DATA:    act = fpu_en ? ACT_DATA    : ACT_TRAP;
        default:           act = ACT_ILLEGAL;
      endcase
    end else if ((aux_wr || aux_rd) && aux_sel == AUX_STATUS_ID) begin
      if (!fpu_en)     act = ACT_TRAP;
      else if (aux_wr) act = ACT_SR_WR;
      else             act = ACT_SR_RD;
    end
  end
endmodule

// File: rtl/bau_addr.sv
module bau_addr #(
  parameter int DATA_W = 64,
  parameter int OFF_W  = 3
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] aligned,
  output logic [OFF_W-1:0]  off,
  output logic [OFF_W-1:0]  off_le
);
  logic [DATA_W-1:0] sum;

  always_comb begin
    sum     = a + b;
    aligned = {sum[DATA_W-1:OFF_W], {OFF_W{1'b0}}};
    off     = sum[OFF_W-1:0];
    off_le  = {OFF_W{1'b0}} - sum[OFF_W-1:0];
  end
endmodule

// File: rtl/bau_funnel.sv
module bau_funnel #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int NLANE = DATA_W / LANE_W,
  localparam int SEL_W = $clog2(NLANE)
) (
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] lo,
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] cand [NLANE];

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    if (k == 0) begin : g_zero
      assign cand[k] = hi;
    end else begin : g_mix
      assign cand[k] = {hi[DATA_W-1-k*LANE_W:0], lo[DATA_W-1:DATA_W-k*LANE_W]};
    end
  end

  assign y = cand[sel];
endmodule

// File: rtl/byte_align_unit.sv
module byte_align_unit
  import bau_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int OFF_W = $clog2(DATA_W / LANE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [DATA_W-1:0] int_a,
  input  logic [DATA_W-1:0] int_b,
  input  logic [DATA_W-1:0] fp_a,
  input  logic [DATA_W-1:0] fp_b,
  input  logic              fpu_en,
  input  logic              aux_rd,
  input  logic              aux_wr,
  input  logic [AUX_W-1:0]  aux_sel,
  input  logic [DATA_W-1:0] aux_wdata,
  output logic [DATA_W-1:0] int_result,
  output logic [DATA_W-1:0] fp_result,
  output logic              fpu_trap,
  output logic              illegal_op
);
  act_e              act;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] aligned;
  logic [OFF_W-1:0]  off, off_le;
  logic [DATA_W-1:0] funnel_y;

  bau_decode u_dec (
    .op_valid(op_valid), .op_code(op_code), .fpu_en(fpu_en),
    .aux_rd(aux_rd), .aux_wr(aux_wr), .aux_sel(aux_sel), .act(act)
  );

  bau_addr #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_addr (
    .a(int_a), .b(int_b), .aligned(aligned), .off(off), .off_le(off_le)
  );

  bau_funnel #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_funnel (
    .hi(fp_a), .lo(fp_b), .sel(status_q[OFF_W-1:0]), .y(funnel_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q   <= '0;
      int_result <= '0;
      fp_result  <= '0;
      fpu_trap   <= 1'b0;
      illegal_op <= 1'b0;
    end else begin
      fpu_trap   <= 1'b0;
      illegal_op <= 1'b0;
      case (act)
        ACT_ADDR: begin
          int_result             <= aligned;
          status_q[OFF_W-1:0]    <= off;
        end
        ACT_ADDR_LE: begin
          int_result             <= aligned;
          status_q[OFF_W-1:0]    <= off_le;
        end
        ACT_DATA:    fp_result   <= funnel_y;
        ACT_SR_WR:   status_q    <= aux_wdata;
        ACT_SR_RD:   int_result  <= status_q;
        ACT_TRAP:    fpu_trap    <= 1'b1;
        ACT_ILLEGAL: illegal_op  <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bau_chk.sv
module bau_chk
  import bau_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OFF_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [OPC_W-1:0]  op_code,
  input logic [DATA_W-1:0] fp_a,
  input logic              fpu_en,
  input logic              aux_rd,
  input logic              aux_wr,
  input logic [DATA_W-1:0] int_result,
  input logic [DATA_W-1:0] fp_result,
  input logic              fpu_trap,
  input logic              illegal_op,
  input logic [DATA_W-1:0] status_q
);
  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> !fpu_trap);

  // R5
  illegal_cause_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> $past(op_valid));

  // R6
  trap_cause_chk: assert property (@(posedge clk) disable iff (rst)
    fpu_trap |-> $past(!fpu_en && (op_valid || aux_rd || aux_wr)));

  // R6
  disabled_status_chk: assert property (@(posedge clk) disable iff (rst)
    !fpu_en |=> $stable(status_q));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !aux_rd && !aux_wr) |=>
      ($stable(int_result) && $stable(fp_result) && !fpu_trap && !illegal_op));

  // R2
  addr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && fpu_en && (op_code == OPC_ALIGN_ADDR || op_code == OPC_ALIGN_ADDR_LE))
      |=> int_result[OFF_W-1:0] == '0);

  // R4
  zero_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && fpu_en && op_code == OPC_ALIGN_DATA && status_q[OFF_W-1:0] == '0)
      |=> fp_result == $past(fp_a));
endmodule

bind byte_align_unit bau_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .fp_a(fp_a),
  .fpu_en(fpu_en), .aux_rd(aux_rd), .aux_wr(aux_wr), .int_result(int_result),
  .fp_result(fp_result), .fpu_trap(fpu_trap), .illegal_op(illegal_op),
  .status_q(status_q)
);

// File: tb/tb_byte_align_unit.sv
module tb_byte_align_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [8:0]  op_code;
  logic [63:0] int_a, int_b, fp_a, fp_b;
  logic        fpu_en, aux_rd, aux_wr;
  logic [4:0]  aux_sel;
  logic [63:0] aux_wdata;
  logic [63:0] int_result, fp_result;
  logic        fpu_trap, illegal_op;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  byte_align_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .int_a(int_a), .int_b(int_b), .fp_a(fp_a), .fp_b(fp_b), .fpu_en(fpu_en),
    .aux_rd(aux_rd), .aux_wr(aux_wr), .aux_sel(aux_sel), .aux_wdata(aux_wdata),
    .int_result(int_result), .fp_result(fp_result),
    .fpu_trap(fpu_trap), .illegal_op(illegal_op)
  );

  typedef struct packed {
    logic [8:0]  opc;
    logic [63:0] a, b, fa, fb;
  } vec_t;

  localparam int NV = 12;
  localparam logic [63:0] FA = 64'h0011223344556677;
  localparam logic [63:0] FB = 64'h8899AABBCCDDEEFF;
  localparam vec_t VEC [NV] = '{
    '{9'h018, 64'h0000_0000_1000_0003, 64'h2, 64'h0, 64'h0},
    '{9'h048, 64'h0, 64'h0, FA, FB},
    '{9'h01A, 64'h7, 64'h0, 64'h0, 64'h0},
    '{9'h048, 64'h0, 64'h0, FB, FA},
    '{9'h018, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 64'h0},
    '{9'h048, 64'h0, 64'h0, FA, FB},
    '{9'h01A, 64'h10, 64'h4, 64'h0, 64'h0},
    '{9'h048, 64'h0, 64'h0, FA, FB},
    '{9'h018, 64'h6, 64'h1, 64'h0, 64'h0},
    '{9'h048, 64'h0, 64'h0, FA, FB},
    '{9'h01A, 64'h8, 64'h0, 64'h0, 64'h0},
    '{9'h048, 64'h0, 64'h0, FB, FA}
  };

  // bench model state
  logic [63:0] m_st, e_int, e_fp;

  function automatic logic [63:0] pick_bytes(logic [63:0] hi, logic [63:0] lo, int k);
    logic [7:0]  stream [16];
    logic [63:0] r;
    for (int i = 0; i < 8; i++) begin
      stream[i]     = lo[8*i +: 8];
      stream[i + 8] = hi[8*i +: 8];
    end
    r = '0;
    for (int j = 0; j < 8; j++) r[8*j +: 8] = stream[j + 8 - k];
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = 1'b0; aux_rd = 1'b0; aux_wr = 1'b0;
  endtask

  task automatic do_op(logic [8:0] opc, logic [63:0] a, logic [63:0] b,
                       logic [63:0] fa, logic [63:0] fb, logic en);
    @(negedge clk);
    op_valid = 1'b1; op_code = opc; int_a = a; int_b = b;
    fp_a = fa; fp_b = fb; fpu_en = en;
    @(negedge clk);
    idle();
  endtask

  task automatic do_aux(logic wr, logic rd, logic [4:0] sel, logic [63:0] wd, logic en);
    @(negedge clk);
    aux_wr = wr; aux_rd = rd; aux_sel = sel; aux_wdata = wd; fpu_en = en;
    @(negedge clk);
    idle();
  endtask

  task automatic check_status(string tag);
    do_aux(1'b0, 1'b1, 5'h13, 64'h0, 1'b1);
    e_int = m_st;
    check(tag, int_result, m_st);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; idle(); op_code = '0; int_a = '0; int_b = '0; fp_a = '0; fp_b = '0;
    fpu_en = 1'b1; aux_sel = '0; aux_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 int_result", int_result, 64'h0);
    check("R1 fp_result", fp_result, 64'h0);
    check("R1 flags", {62'h0, fpu_trap, illegal_op}, 64'h0);
    m_st = '0; e_int = '0; e_fp = '0;
    check_status("R1 status");

    // vector table: R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      logic [63:0] s;
      do_op(VEC[v].opc, VEC[v].a, VEC[v].b, VEC[v].fa, VEC[v].fb, 1'b1);
      s = VEC[v].a + VEC[v].b;
      case (VEC[v].opc)
        9'h018: begin
          e_int = {s[63:3], 3'b0}; m_st[2:0] = s[2:0];
          check("R2 aligned sum", int_result, e_int);
        end
        9'h01A: begin
          e_int = {s[63:3], 3'b0}; m_st[2:0] = 3'd0 - s[2:0];
          check("R3 aligned sum", int_result, e_int);
        end
        default: begin
          e_fp = pick_bytes(VEC[v].fa, VEC[v].fb, int'(m_st[2:0]));
          check("R4 funnel", fp_result, e_fp);
        end
      endcase
      check("R8 no flags", {62'h0, fpu_trap, illegal_op}, 64'h0);
    end

    // R7 full write then read, R4 with written offset
    do_aux(1'b1, 1'b0, 5'h13, 64'hDEAD_BEEF_0000_0003, 1'b1);
    m_st = 64'hDEAD_BEEF_0000_0003;
    check_status("R7 write/read");
    do_op(9'h048, 0, 0, FA, FB, 1'b1);
    e_fp = pick_bytes(FA, FB, 3);
    check("R4 offset 3", fp_result, e_fp);
    // R2 upper status bits kept
    do_op(9'h018, 64'h5, 64'h1, 0, 0, 1'b1);
    m_st[2:0] = 3'd6;
    check_status("R2 upper bits kept");
    // R3 upper bits kept
    do_op(9'h01A, 64'h3, 64'h0, 0, 0, 1'b1);
    m_st[2:0] = 3'd5;
    check_status("R3 upper bits kept");

    // R8 idle holds results
    @(negedge clk);
    check("R8 hold int", int_result, e_int);
    check("R8 hold fp", fp_result, e_fp);

    // R6 disabled unit
    do_op(9'h048, 0, 0, FB, FA, 1'b0);
    check("R6 trap on data op", {63'h0, fpu_trap}, 64'h1);
    check("R6 fp unchanged", fp_result, e_fp);
    check("R6 no illegal", {63'h0, illegal_op}, 64'h0);
    do_op(9'h018, 64'h1, 64'h1, 0, 0, 1'b0);
    check("R6 trap on addr op", {63'h0, fpu_trap}, 64'h1);
    check("R6 int unchanged", int_result, e_int);
    do_aux(1'b1, 1'b0, 5'h13, 64'h1234, 1'b0);
    check("R6 trap on write", {63'h0, fpu_trap}, 64'h1);
    do_aux(1'b0, 1'b1, 5'h13, 64'h0, 1'b0);
    check("R6 trap on read", {63'h0, fpu_trap}, 64'h1);
    check("R6 read no data", int_result, e_int);
    check_status("R6 status unchanged");
    @(negedge clk);
    check("R8 trap pulse ends", {63'h0, fpu_trap}, 64'h0);

    // R5 illegal opcodes
    do_op(9'h019, 64'h3, 64'h3, FA, FB, 1'b1);
    check("R5 illegal enabled", {62'h0, fpu_trap, illegal_op}, 64'h1);
    check("R5 int unchanged", int_result, e_int);
    check("R5 fp unchanged", fp_result, e_fp);
    do_op(9'h148, 64'h3, 64'h3, FA, FB, 1'b0);
    check("R5 illegal disabled", {62'h0, fpu_trap, illegal_op}, 64'h1);
    check_status("R5 status unchanged");

    // R9 other register number ignored
    do_aux(1'b1, 1'b0, 5'h12, 64'hFFFF, 1'b1);
    check("R9 other write no flag", {62'h0, fpu_trap, illegal_op}, 64'h0);
    do_aux(1'b0, 1'b1, 5'h12, 64'h0, 1'b1);
    check("R9 other read ignored", int_result, e_int);
    check_status("R9 other write ignored");
    // R9 op wins over simultaneous write
    @(negedge clk);
    op_valid = 1'b1; op_code = 9'h018; int_a = 64'h20; int_b = 64'h2; fpu_en = 1'b1;
    aux_wr = 1'b1; aux_sel = 5'h13; aux_wdata = 64'h0;
    @(negedge clk);
    idle();
    e_int = 64'h20; m_st[2:0] = 3'd2;
    check("R9 op result", int_result, e_int);
    check_status("R9 write dropped");

    summary();
    $finish;
  end
endmodule